// File: doc/BRIEF.md
# Banked GPIO controller with key-guarded pin locks

This block gives software a word-wide register port onto a set of general purpose pins grouped in banks of 32. Each bank has an output latch that software changes only through a set register and a clear register, so a single write can raise or lower any group of pins without a read-modify-write. Software can also read back the latch and a synchronised copy of the pad inputs. Every pin has its own control word holding a direction bit plus two stored-only fields: a trigger type and a debounce setting.

Each pin also has a lock bit, held per bank. A pin drives its pad only when it is unlocked and set to output. The lock registers are guarded by a key. Software must write the key value to a dedicated key register. The very next bus write may then update one lock register. Any other write in between disarms the key. Reads do not disarm it.

Top module: `gpio_lockctl`

## Requirements
- R1: After reset every output latch is 0, every lock bit is 1, every control word reads 0x001 (input), and no output enable is asserted.
- R2: Pin p belongs to bank p>>5 at bit p&31. The per-bank registers sit at bank*4 above their base: output status 0x000, input status 0x020, set 0x040, clear 0x060, lock 0x500. The control word of pin p sits at byte offset 0x100 + p*4. The port takes the word address, which is the byte offset divided by 4.
- R3: Writing the set register drives high every latch bit whose data bit is 1. Bits written as 0 keep their value.
- R4: Writing the clear register drives low every latch bit whose data bit is 1. Bits written as 0 keep their value.
- R5: Output status reads return the bank's output latch. Input status reads return the pad inputs through a two-flop synchroniser, so a pad change is visible in the second read cycle after the change and not in the first.
- R6: Control word bits 8:0 are stored and read back. Bit 0 is the direction (1 input, 0 output), bits 4:3 the trigger type and bits 8:5 the debounce setting. Bits 31:9 read as 0.
- R7: A pin's output enable is high exactly when its direction bit is 0 and its lock bit is 0. The pin's output value always equals its latch bit.
- R8: A write of 0x00A5A501 to byte offset 0x520 arms the key. If the next write targets a lock register, that write replaces the register's value. Reads between the two writes do not disarm the key.
- R9: A lock write is ignored when the write just before it was not the key. This covers a key followed by another write, a wrong key value, and a second lock write after one that was accepted.
- R10: Set and clear writes to a pin whose direction bit is 1 still update its latch, which reads back through output status. The output enable stays low until the pin becomes an unlocked output.
- R11: Unmapped offsets read 0 and writes to them change nothing. These include the interrupt register ranges 0x080 to 0x0DC, registers of banks at or above the configured count, control words past the last pin, and the key register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| gpio_in | input | NUM_BANKS*32 | Pad inputs |
| gpio_out | output | NUM_BANKS*32 | Pad output values (the latches) |
| gpio_oe | output | NUM_BANKS*32 | Pad output enables |

## Verification
The bench goes after the one-shot nature of the key. It places a write, a wrong key value or a second lock write between a key and a lock write, and it places a read between a key and a lock write. A design that left the key armed would accept the stray lock updates, and one that disarmed on reads would refuse the legal update. It sweeps every pin's control word and set and clear bit, with patterns that carry zero bits, to catch a wrong bank or bit mapping and any clobbering of unwritten bits. It also probes the synchroniser depth with reads one and two cycles after a pad change, and it checks that latch writes to input pins leave the enable low, which a design that drives on every set would break.

// File: rtl/gpio_lockctl_pkg.sv
package gpio_lockctl_pkg;
  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned WADDR_W       = 10;
  localparam int unsigned CTRL_W        = 9;
  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h001;
  localparam logic [31:0] KEY_VALUE     = 32'h00A5_A501;
  localparam logic [WADDR_W-1:0] KEY_WADDR = 10'h148;

  typedef enum logic [2:0] {
    RG_NONE, RG_OUT, RG_IN, RG_SET, RG_CLR, RG_CTRL, RG_LOCK, RG_KEY
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] bank;
    logic [7:0] pin;
  } reg_hit_t;
endpackage

// File: rtl/gpio_lockctl_rstsync.sv
module gpio_lockctl_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ns = stage_q[1];
endmodule

// File: rtl/gpio_lockctl_decode.sv
module gpio_lockctl_decode
  import gpio_lockctl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [WADDR_W-1:0] waddr,
  output reg_hit_t           hit
);
  localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK;

  logic [WADDR_W-1:0] pin_ofs;
  logic               bank_ok;

  assign pin_ofs = waddr - 10'h040;
  assign bank_ok = int'(waddr[2:0]) < NUM_BANKS;

  always_comb begin
    hit      = '0;
    hit.kind = RG_NONE;
    if (waddr < 10'h040) begin
      hit.bank = waddr[2:0];
      if (bank_ok) begin
        case (waddr[5:3])
          3'd0:    hit.kind = RG_OUT;
          3'd1:    hit.kind = RG_IN;
          3'd2:    hit.kind = RG_SET;
          3'd3:    hit.kind = RG_CLR;
          default: hit.kind = RG_NONE;
        endcase
      end
    end else if (waddr < 10'h140) begin
      hit.pin = pin_ofs[7:0];
      if (int'(pin_ofs) < NUM_PINS) hit.kind = RG_CTRL;
    end else if (waddr[9:3] == 7'h28) begin
      hit.bank = waddr[2:0];
      if (bank_ok) hit.kind = RG_LOCK;
    end else if (waddr == KEY_WADDR) begin
      hit.kind = RG_KEY;
    end
  end
endmodule

// File: rtl/gpio_lockctl_key.sv
module gpio_lockctl_key
  import gpio_lockctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        key_hit,
  input  logic [31:0] wdata,
  output logic        armed
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = key_hit && (wdata == KEY_VALUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= armed_d;
  end

  assign armed = armed_q;

  assert_key_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && wr_en && !key_hit) |=> !armed_q);
endmodule

// File: rtl/gpio_lockctl_bank.sv
module gpio_lockctl_bank
  import gpio_lockctl_pkg::*;
#(
  parameter int unsigned PINS = PINS_PER_BANK,
  localparam int unsigned SEL_W = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pad_in,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              lock_we,
  input  logic              ctrl_we,
  input  logic [SEL_W-1:0]  ctrl_sel,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   in_q,
  output logic [PINS-1:0]   lock_q,
  output logic [PINS-1:0]   oe,
  output logic [CTRL_W-1:0] ctrl_rd
);
  logic [PINS-1:0]   out_d;
  logic [PINS-1:0]   meta_q;
  logic [PINS-1:0]   dir;
  logic [CTRL_W-1:0] ctrl_q [PINS];

  always_comb begin
    out_d = out_q;
    if (set_we) out_d = out_d | wdata;
    if (clr_we) out_d = out_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                out_q <= '0;
    else if (set_we || clr_we) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      in_q   <= '0;
    end else begin
      meta_q <= pad_in;
      in_q   <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '1;
    else if (lock_we) lock_q <= wdata;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic ctrl_en;
    assign ctrl_en = ctrl_we && (ctrl_sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q[i] <= CTRL_RST;
      else if (ctrl_en) ctrl_q[i] <= wdata[CTRL_W-1:0];
    end
    assign dir[i] = ctrl_q[i][0];
  end

  assign oe      = ~dir & ~lock_q;
  assign ctrl_rd = ctrl_q[ctrl_sel];

  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((out_q & $past(wdata)) == $past(wdata)));
  assert_clr_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((out_q & $past(wdata)) == '0));
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(out_q));
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_we |=> $stable(lock_q));
endmodule

// File: rtl/gpio_lockctl.sv
module gpio_lockctl
  import gpio_lockctl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [WADDR_W-1:0]  bus_waddr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe
);
  logic     rst_ns;
  logic     wr_en;
  logic     armed;
  reg_hit_t hit;

  logic [PINS_PER_BANK-1:0] out_b  [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] in_b   [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] lock_b [NUM_BANKS];
  logic [CTRL_W-1:0]        ctrl_b [NUM_BANKS];
  logic [NUM_PINS-1:0]      lock_all;

  gpio_lockctl_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  gpio_lockctl_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (.waddr(bus_waddr), .hit(hit));

  assign wr_en = bus_sel && bus_we;

  gpio_lockctl_key u_key (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en),
    .key_hit(hit.kind == RG_KEY), .wdata(bus_wdata), .armed(armed)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_hit, pin_bank_hit;
    assign bank_hit     = (hit.bank == 3'(b));
    assign pin_bank_hit = (hit.pin[7:5] == 3'(b));

    gpio_lockctl_bank #(.PINS(PINS_PER_BANK)) u_bank (
      .clk(clk), .rst_n(rst_ns),
      .pad_in(gpio_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .set_we(wr_en && hit.kind == RG_SET && bank_hit),
      .clr_we(wr_en && hit.kind == RG_CLR && bank_hit),
      .lock_we(wr_en && armed && hit.kind == RG_LOCK && bank_hit),
      .ctrl_we(wr_en && hit.kind == RG_CTRL && pin_bank_hit),
      .ctrl_sel(hit.pin[4:0]),
      .wdata(bus_wdata),
      .out_q(out_b[b]), .in_q(in_b[b]), .lock_q(lock_b[b]),
      .oe(gpio_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .ctrl_rd(ctrl_b[b])
    );

    assign gpio_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_b[b];
    assign lock_all[b*PINS_PER_BANK +: PINS_PER_BANK] = lock_b[b];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(hit.bank) == b) begin
          case (hit.kind)
            RG_OUT:  bus_rdata = out_b[b];
            RG_IN:   bus_rdata = in_b[b];
            RG_LOCK: bus_rdata = lock_b[b];
            default: ;
          endcase
        end
        if (hit.kind == RG_CTRL && int'(hit.pin[7:5]) == b)
          bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_b[b]};
      end
    end
  end

  assert_lock_needs_key_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(lock_all) |-> $past(armed));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_sel && !bus_we && (hit.kind == RG_NONE || hit.kind == RG_KEY)) |-> (bus_rdata == '0));
  assert_oe_locked_low_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    ((gpio_oe & lock_all) == '0));
endmodule

// File: tb/gpio_lockctl_test.sv
module gpio_lockctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int NP = NB * 32;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [9:0]    bus_waddr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out;
  logic [NP-1:0] gpio_oe;

  int vectors = 0;
  int fails = 0;

  logic [NP-1:0] m_out, m_lock, m_dir;

  gpio_lockctl #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = ofs[11:2]; bus_wdata = data;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ofs, output logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = ofs[11:2];
    #(CLK_PERIOD/2 - 1) data = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic key();
    wr(12'h520, 32'h00A5_A501);
  endtask

  task automatic chk_pins(input string tag);
    @(negedge clk);
    chk({tag, " out"}, gpio_out, m_out);
    chk({tag, " oe"}, gpio_oe, ~m_dir & ~m_lock);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; vectors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_out = '0; m_lock = '1; m_dir = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state, R2 mapping of every bank and control word
    chk_pins("R1 reset");
    for (int b = 0; b < NB; b++) begin
      rd(12'(b*4), d);          chk("R1 out status", d, 0);
      rd(12'h500 + 12'(b*4), d); chk("R1 lock status", d, 32'hFFFF_FFFF);
    end
    for (int p = 0; p < NP; p++) begin
      rd(12'h100 + 12'(p*4), d); chk("R1 R2 ctrl reset", d, 1);
    end

    // R11 unmapped offsets
    rd(12'h080, d); chk("R11 int status", d, 0);
    rd(12'h0A0, d); chk("R11 int mask", d, 0);
    rd(12'h0C0, d); chk("R11 int mask clr", d, 0);
    rd(12'h008, d); chk("R11 bank2 out", d, 0);
    rd(12'h520, d); chk("R11 key read", d, 0);
    rd(12'h200, d); chk("R11 ctrl past last", d, 0);
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h200, 32'h0);
    wr(12'h080, 32'hFFFF_FFFF);
    chk_pins("R11 writes ignored");
    rd(12'h100 + 12'((NP-1)*4), d); chk("R11 last ctrl intact", d, 1);

    // R9 lock writes without a fresh key
    wr(12'h500, 32'h0);
    rd(12'h500, d); chk("R9 no key", d, 32'hFFFF_FFFF);
    key(); wr(12'h100, 32'h1); wr(12'h500, 32'h0);
    rd(12'h500, d); chk("R9 key then other write", d, 32'hFFFF_FFFF);
    key(); wr(12'h520, 32'h00A5_A500); wr(12'h500, 32'h0);
    rd(12'h500, d); chk("R9 wrong key", d, 32'hFFFF_FFFF);

    // R8 key, read, lock write accepted; R9 second write refused
    key(); rd(12'h000, d); wr(12'h500, 32'hFFFF_0000);
    rd(12'h500, d); chk("R8 accepted after read", d, 32'hFFFF_0000);
    wr(12'h500, 32'h0);
    rd(12'h500, d); chk("R9 second lock write", d, 32'hFFFF_0000);
    key(); wr(12'h500, 32'h0);
    key(); wr(12'h504, 32'h0);
    m_lock = '0;
    rd(12'h504, d); chk("R8 bank1 unlock", d, 0);

    // R2 R3 R4 R6 R7 sweep over every pin
    for (int p = 0; p < NP; p++) begin
      logic [31:0] cv, bm;
      logic [11:0] bo;
      cv = 32'(((p % 16) << 5) | ((p % 4) << 3));
      bo = 12'((p >> 5) * 4);
      bm = 32'h1 << (p & 31);
      wr(12'h100 + 12'(p*4), 32'hFFFF_FE00 | cv);
      m_dir[p] = 1'b0;
      rd(12'h100 + 12'(p*4), d); chk("R6 ctrl readback", d, cv);
      wr(12'h040 + bo, bm); m_out[p] = 1'b1;
      chk_pins("R3 R7 set pin");
      rd(bo, d); chk("R2 R5 out status", d, m_out[bo[4:2]*32 +: 32]);
      wr(12'h060 + bo, bm); m_out[p] = 1'b0;
      chk_pins("R4 clear pin");
    end

    // R3 R4 multi-bit patterns with zero bits
    wr(12'h040, 32'hA5A5_0F0F); m_out[31:0] = 32'hA5A5_0F0F;
    wr(12'h044, 32'h1234_5678); m_out[63:32] = 32'h1234_5678;
    wr(12'h040, 32'h0000_F000); m_out[31:0] |= 32'h0000_F000;
    wr(12'h060, 32'h8001_0001); m_out[31:0] &= ~32'h8001_0001;
    wr(12'h064, 32'h0000_0078); m_out[63:32] &= ~32'h0000_0078;
    rd(12'h000, d); chk("R3 R4 bank0 pattern", d, m_out[31:0]);
    rd(12'h004, d); chk("R3 R4 bank1 pattern", d, m_out[63:32]);
    chk_pins("R3 R4 pattern pins");

    // R5 input synchroniser depth
    foreach (m_out[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] prev, nxt;
      prev = gpio_in;
      nxt = {32'hDEAD_0000 ^ 32'(k * 32'h1357_9BDF), 32'h0F0F_00FF ^ 32'(k * 32'h2468_ACE1)};
      @(negedge clk) gpio_in = nxt;
      rd(12'h020, d); chk("R5 in stale bank0", d, prev[31:0]);
      rd(12'h020, d); chk("R5 in new bank0", d, nxt[31:0]);
      rd(12'h024, d); chk("R5 in new bank1", d, nxt[63:32]);
    end

    // R10 latch writes to an input pin
    wr(12'h114, 32'h1); m_dir[5] = 1'b1;
    wr(12'h060, 32'h20); m_out[5] = 1'b0;
    wr(12'h040, 32'h20); m_out[5] = 1'b1;
    rd(12'h000, d); chk("R10 latch on input pin", d, m_out[31:0]);
    chk_pins("R10 input pin not enabled");
    wr(12'h114, 32'h0); m_dir[5] = 1'b0;
    chk_pins("R10 becomes output");

    // R7 relock one pin of an output
    key(); wr(12'h504, 32'h8); m_lock[35] = 1'b1;
    chk_pins("R7 relocked pin");
    rd(12'h504, d); chk("R8 relock readback", d, 32'h8);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule